// File: doc/BRIEF.md
# Register-Driven SPI Master Shift Engine

This block is a byte-wide SPI master driven by a small register window. Software sets up a control register that holds the enable, the master-select, the interrupt enable and a clock-divider select. A write to the data register then starts an 8-bit full-duplex exchange in clock mode 0. While the exchange runs, the data register still reads back the byte that was written. At the end the byte clocked in from the slave replaces it, and a completion flag is raised.

If the data register is written while a transfer is already running, the running transfer carries on undisturbed. The write is dropped and a collision flag records it. Both flags are cleared by the next write that starts a transfer. The completion flag can also be cleared by writing a 1 to its bit. An interrupt request output follows the completion flag when the interrupt enable is set.

Top module: `spi_master_ctl`

## Requirements
- R1: After a synchronous active-low reset, the control, status and data registers read 0, and `busy`, `irq`, `sck` and `mosi` are low.
- R2: Register window: address 0 is control (bit0 enable, bit1 master, bit2 interrupt enable, bits5:3 divider select, upper bits read 0), address 1 is status (bit0 completion, bit1 collision), address 2 is data, address 3 reads 0. `reg_rdata` follows `reg_addr` combinationally.
- R3: A data write while idle, with enable and master both set, starts a transfer. `busy` is high from the next cycle for exactly 8*D cycles, with D = 2 << select for select 0..6 and D = 128 for select 7.
- R4: In mode 0, `sck` and `mosi` are low when idle. Each bit holds `sck` low for D/2 cycles and then high for D/2 cycles. `mosi` sends the written byte MSB first and changes only when a transfer starts or `sck` falls.
- R5: `miso` is sampled on the cycle `sck` rises. The data register keeps the written byte during the transfer and takes the received byte in the cycle the transfer ends.
- R6: At the end of a transfer the completion flag is set, and `irq` equals completion AND interrupt enable.
- R7: A data write while `busy` neither restarts nor lengthens the transfer, leaves the data register unchanged, and sets the collision flag. This includes a write in the final cycle.
- R8: A write that starts a transfer clears both the completion and the collision flags.
- R9: Writing status with bit0 = 1 clears completion. Bit0 = 0 has no effect, and status writes never change collision. If a transfer ends in the same cycle as a clear, completion ends up set.
- R10: A data write while enable or master is clear stores the byte and starts nothing.
- R11: Changing the divider select during a transfer does not change that transfer's timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, one cycle |
| reg_addr | input | 2 | Register select for write and read |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| busy | output | 1 | Transfer in progress |
| irq | output | 1 | Interrupt request (level) |
| sck | output | 1 | Serial clock, mode 0 |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The assertions assume that `reg_wr` is a single-cycle strobe with a known `reg_addr`. They also assume that `miso` holds steady around the cycle where `sck` rises. The bench drives every register input on the falling clock edge for exactly one cycle. It derives `miso` from a slave byte, indexed by the bit position its own model predicts, and changes it only on falling edges, so each sample is well defined. Writes that land on the last cycle of a transfer are placed there on purpose, using the model's cycle count.

// File: rtl/spi_master_pkg.sv
// Shared register encodings and the control-register layout for the SPI master.
// Assumes an 8-bit register window with four addresses.
package spi_master_pkg;

    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_STAT = 2'd1,
        REG_DATA = 2'd2,
        REG_NONE = 2'd3
    } reg_sel_e;

    // Control register layout, MSB first: divider select, irq enable, master, enable
    typedef struct packed {
        logic [2:0] div_sel;
        logic       irq_en;
        logic       master;
        logic       enable;
    } ctrl_t;

    localparam int CTRL_W    = 6;
    localparam int STAT_DONE = 0;
    localparam int STAT_COLL = 1;

endpackage

// File: rtl/spi_bit_timer.sv
// Bit timer: paces one transfer of BITS bits, each 2*half cycles long.
// Drives the mode-0 serial clock and emits rise, fall and last-bit strobes.
// Assumes start is never asserted while active; the divider is latched at start.
module spi_bit_timer #(
    parameter int BITS    = 8,
    parameter int SEL_W   = 3,
    parameter int MAXLOG  = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [SEL_W-1:0] div_sel,
    output logic             active,
    output logic             sck,
    output logic             rise_stb,
    output logic             fall_stb,
    output logic             last_stb
);
    localparam int PH_W  = MAXLOG;
    localparam int CNT_W = (BITS > 1) ? $clog2(BITS) : 1;

    logic [PH_W-1:0]  ph_q;
    logic [PH_W-1:0]  half_q;
    logic [PH_W:0]    full_m1;
    logic [CNT_W-1:0] bit_q;
    logic             sck_q;

    // Half-period for a select value, capped at the largest divider
    function automatic logic [PH_W-1:0] half_of(input logic [SEL_W-1:0] s);
        if (int'(s) >= MAXLOG - 1) return PH_W'(1) << (MAXLOG - 1);
        else                       return PH_W'(1) << s;
    endfunction

    // Strobes decoded from the phase counter
    always_comb begin
        full_m1  = {half_q, 1'b0} - 1'b1;
        rise_stb = active && (ph_q == half_q - 1'b1);
        fall_stb = active && ({1'b0, ph_q} == full_m1);
        last_stb = fall_stb && (bit_q == CNT_W'(BITS - 1));
    end

    // Phase, bit and serial clock sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            ph_q   <= '0;
            half_q <= PH_W'(1);
            bit_q  <= '0;
            sck_q  <= 1'b0;
        end else if (start) begin
            active <= 1'b1;
            ph_q   <= '0;
            half_q <= half_of(div_sel);
            bit_q  <= '0;
            sck_q  <= 1'b0;
        end else if (active) begin
            if (fall_stb) begin
                ph_q  <= '0;
                sck_q <= 1'b0;
                if (last_stb) active <= 1'b0;
                else          bit_q  <= bit_q + 1'b1;
            end else begin
                ph_q <= ph_q + 1'b1;
                if (rise_stb) sck_q <= 1'b1;
            end
        end
    end

    assign sck = sck_q;

endmodule

// File: rtl/spi_shifter.sv
// Transmit and receive shift registers for one MSB-first transfer.
// Loads at start, shifts out on the falling strobe, samples in on the rising strobe.
// Assumes strobes come from spi_bit_timer and never coincide with start.
module spi_shifter #(
    parameter int BITS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [BITS-1:0] load,
    input  logic            rise_stb,
    input  logic            fall_stb,
    input  logic            active,
    input  logic            miso,
    output logic            mosi,
    output logic [BITS-1:0] rx
);
    logic [BITS-1:0] tx_q;
    logic [BITS-1:0] rx_q;

    // Outgoing byte: load then shift left on each falling edge
    always_ff @(posedge clk) begin
        if (!rst_n)        tx_q <= '0;
        else if (start)    tx_q <= load;
        else if (fall_stb) tx_q <= {tx_q[BITS-2:0], 1'b0};
    end

    // Incoming byte: shift in the serial input on each rising edge
    always_ff @(posedge clk) begin
        if (!rst_n)        rx_q <= '0;
        else if (rise_stb) rx_q <= {rx_q[BITS-2:0], miso};
    end

    assign mosi = active & tx_q[BITS-1];
    assign rx   = rx_q;

endmodule

// File: rtl/spi_master_ctl.sv
// SPI master top: register window (control, status, data), start and collision
// logic, completion flag and interrupt level. Serial timing lives in spi_bit_timer,
// shifting in spi_shifter. Assumes single-cycle write strobes.
module spi_master_ctl #(
    parameter int XFER_BITS    = 8,
    parameter int DIV_SEL_W    = 3,
    parameter int DIV_MAX_LOG2 = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic [1:0]           reg_addr,
    input  logic [XFER_BITS-1:0] reg_wdata,
    output logic [XFER_BITS-1:0] reg_rdata,
    output logic                 busy,
    output logic                 irq,
    output logic                 sck,
    output logic                 mosi,
    input  logic                 miso
);
    import spi_master_pkg::*;

    localparam int PAD_W = XFER_BITS - CTRL_W;

    ctrl_t                ctrl_q;
    logic                 done_q;
    logic                 coll_q;
    logic [XFER_BITS-1:0] data_q;
    logic [XFER_BITS-1:0] rx_w;
    logic                 wr_ctrl, wr_stat, wr_data;
    logic                 start_w;
    logic                 rise_w, fall_w, last_w;
    logic                 ctrl_en, ctrl_master;

    // Write decode and transfer start qualification
    always_comb begin
        wr_ctrl     = reg_wr && (reg_sel_e'(reg_addr) == REG_CTRL);
        wr_stat     = reg_wr && (reg_sel_e'(reg_addr) == REG_STAT);
        wr_data     = reg_wr && (reg_sel_e'(reg_addr) == REG_DATA);
        ctrl_en     = ctrl_q.enable;
        ctrl_master = ctrl_q.master;
        start_w     = wr_data && !busy && ctrl_en && ctrl_master;
    end

    spi_bit_timer #(
        .BITS   (XFER_BITS),
        .SEL_W  (DIV_SEL_W),
        .MAXLOG (DIV_MAX_LOG2)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start_w),
        .div_sel  (ctrl_q.div_sel),
        .active   (busy),
        .sck      (sck),
        .rise_stb (rise_w),
        .fall_stb (fall_w),
        .last_stb (last_w)
    );

    spi_shifter #(
        .BITS (XFER_BITS)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start_w),
        .load     (reg_wdata),
        .rise_stb (rise_w),
        .fall_stb (fall_w),
        .active   (busy),
        .miso     (miso),
        .mosi     (mosi),
        .rx       (rx_w)
    );

    // Control register
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (wr_ctrl) ctrl_q <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
    end

    // Data register: received byte at completion, else an idle write
    always_ff @(posedge clk) begin
        if (!rst_n)                data_q <= '0;
        else if (last_w)           data_q <= rx_w;
        else if (wr_data && !busy) data_q <= reg_wdata;
    end

    // Completion flag: set at end, cleared by start or write-one
    always_ff @(posedge clk) begin
        if (!rst_n)                             done_q <= 1'b0;
        else if (last_w)                        done_q <= 1'b1;
        else if (start_w)                       done_q <= 1'b0;
        else if (wr_stat && reg_wdata[STAT_DONE]) done_q <= 1'b0;
    end

    // Collision flag: set by a data write while busy, cleared by start
    always_ff @(posedge clk) begin
        if (!rst_n)               coll_q <= 1'b0;
        else if (wr_data && busy) coll_q <= 1'b1;
        else if (start_w)         coll_q <= 1'b0;
    end

    // Read multiplexer
    always_comb begin
        unique case (reg_sel_e'(reg_addr))
            REG_CTRL: reg_rdata = {{PAD_W{1'b0}}, ctrl_q};
            REG_STAT: reg_rdata = {{(XFER_BITS-2){1'b0}}, coll_q, done_q};
            REG_DATA: reg_rdata = data_q;
            default:  reg_rdata = '0;
        endcase
    end

    assign irq = done_q & ctrl_q.irq_en;

endmodule

// File: rtl/spi_master_ctl_chk.sv
// Assertion checker for spi_master_ctl, attached with bind below.
// Assumes single-cycle write strobes and a known register address.
module spi_master_ctl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_wr,
    input logic [1:0] reg_addr,
    input logic       busy,
    input logic       sck,
    input logic       mosi,
    input logic       done_q,
    input logic       coll_q,
    input logic       ctrl_en,
    input logic       ctrl_master
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!sck && !mosi)); // R4

    AST_MOSI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !$fell(sck)) |-> $stable(mosi)); // R4

    AST_SCK_IN_XFER: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sck) |-> busy); // R4

    AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done_q); // R6

    AST_COLL_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd2 && busy) |=> coll_q); // R7

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd2 && !busy && ctrl_en && ctrl_master)
        |=> (busy && !done_q && !coll_q)); // R8

endmodule

bind spi_master_ctl spi_master_ctl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .busy        (busy),
    .sck         (sck),
    .mosi        (mosi),
    .done_q      (done_q),
    .coll_q      (coll_q),
    .ctrl_en     (ctrl_en),
    .ctrl_master (ctrl_master)
);

// File: tb/spi_master_ctl_bench.sv
// Bench for spi_master_ctl: behavioural cycle model compared every clock,
// plus directed checks per requirement.
module spi_master_ctl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       busy, irq, sck, mosi;
    logic       miso = 1'b0;

    spi_master_ctl u_spi_master_ctl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy), .irq(irq),
        .sck(sck), .mosi(mosi), .miso(miso)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    int run     = 0;
    int last_run = 0;
    bit finished = 0;

    // Reference model state
    bit       m_busy = 0, m_done = 0, m_coll = 0;
    int       m_cnt = 0, m_div = 2;
    bit [5:0] m_ctrl = 0;
    bit [7:0] m_data = 0, m_tx = 0, m_rx = 0;
    bit [7:0] slave = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    // Model: advance one clock from the inputs present at this edge
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_coll = 0; m_cnt = 0; m_div = 2;
            m_ctrl = 0; m_data = 0; m_tx = 0; m_rx = 0;
        end else begin
            bit was_busy, compl, wd, ws, wc;
            was_busy = m_busy;
            compl = m_busy && (m_cnt == 8*m_div - 1);
            wd = reg_wr && reg_addr == 2'd2;
            ws = reg_wr && reg_addr == 2'd1;
            wc = reg_wr && reg_addr == 2'd0;
            if (m_busy) begin
                if (m_cnt % m_div == m_div/2 - 1) m_rx = {m_rx[6:0], miso};
                if (compl) begin m_busy = 0; m_data = m_rx; m_done = 1; end
                else m_cnt++;
            end
            if (wd && was_busy) m_coll = 1;
            else if (wd) begin
                m_data = reg_wdata;
                if (m_ctrl[0] && m_ctrl[1]) begin
                    m_busy = 1; m_cnt = 0; m_tx = reg_wdata;
                    m_div = (m_ctrl[5:3] >= 6) ? 128 : (2 << m_ctrl[5:3]);
                    m_done = 0; m_coll = 0;
                end
            end
            if (ws && reg_wdata[0] && !compl) m_done = 0;
            if (wc) m_ctrl = reg_wdata[5:0];
        end
        if (cyc > WATCHDOG) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected <= %0d cycles", cyc, WATCHDOG);
            summary();
        end
    end

    // Slave: present the predicted bit on each falling edge
    always @(negedge clk) begin
        miso = m_busy ? slave[7 - m_cnt/m_div] : 1'b0;
    end

    // Per-cycle comparison away from both edges
    always @(negedge clk) begin
        #(CLK_PERIOD/4);
        if (rst_n) begin
            bit e_sck, e_mosi;
            bit [7:0] e_rd;
            e_sck  = m_busy && ((m_cnt % m_div) >= m_div/2);
            e_mosi = m_busy && m_tx[7 - m_cnt/m_div];
            case (reg_addr)
                2'd0: e_rd = {2'b00, m_ctrl};
                2'd1: e_rd = {6'd0, m_coll, m_done};
                2'd2: e_rd = m_data;
                default: e_rd = 8'd0;
            endcase
            chk(busy == m_busy, "R3", "busy", busy, m_busy);
            chk(sck == e_sck, "R4", "sck", sck, e_sck);
            chk(mosi == e_mosi, "R4", "mosi", mosi, e_mosi);
            chk(irq == (m_done && m_ctrl[2]), "R6", "irq", irq, m_done && m_ctrl[2]);
            chk(reg_rdata == e_rd, "R2", "rdata", reg_rdata, e_rd);
            if (busy) run++;
            else if (run > 0) begin last_run = run; run = 0; end
        end
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [7:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic wait_idle;
        while (m_busy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic wait_final;
        while (!(m_busy && m_cnt == 8*m_div - 1)) @(negedge clk);
    endtask

    initial begin
        logic [7:0] v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        for (int a = 0; a < 4; a++) begin
            peek(2'(a), v);
            chk(v == 8'h00, "R1", "reset reg", v, 0);
        end
        chk(!busy && !irq && !sck && !mosi, "R1", "reset outputs",
            {busy, irq, sck, mosi}, 0);

        // R2: control read-back and unused address
        wr(2'd0, 8'hEB);
        peek(2'd0, v); chk(v == 8'h2B, "R2", "ctrl readback", v, 8'h2B);
        peek(2'd3, v); chk(v == 8'h00, "R2", "addr3", v, 0);

        // R10: no transfer without enable or without master
        wr(2'd0, 8'h02);
        wr(2'd2, 8'h77);
        repeat (3) @(negedge clk);
        peek(2'd2, v);
        chk(!busy && v == 8'h77, "R10", "master only", {busy, v}, 8'h77);
        wr(2'd0, 8'h01);
        wr(2'd2, 8'h12);
        repeat (3) @(negedge clk);
        peek(2'd2, v);
        chk(!busy && v == 8'h12, "R10", "enable only", {busy, v}, 8'h12);

        // R3 R4 R5: divider 2, no interrupt enable
        wr(2'd0, 8'h03);
        slave = 8'hA5;
        wr(2'd2, 8'h3C);
        peek(2'd2, v);
        chk(busy && v == 8'h3C, "R5", "data during xfer", v, 8'h3C);
        wait_idle();
        chk(last_run == 16, "R3", "busy length D=2", last_run, 16);
        peek(2'd2, v); chk(v == 8'hA5, "R5", "rx byte", v, 8'hA5);
        peek(2'd1, v); chk(v == 8'h01, "R6", "done flag", v, 1);
        chk(!irq, "R6", "irq masked", irq, 0);

        // R6 R8: divider 8 with interrupt enable
        wr(2'd0, 8'h17);
        chk(irq, "R6", "irq on enable", irq, 1);
        slave = 8'h5A;
        wr(2'd2, 8'hC3);
        peek(2'd1, v); chk(v == 8'h00, "R8", "start clears done", v, 0);
        wait_idle();
        chk(last_run == 64, "R3", "busy length D=8", last_run, 64);
        chk(irq, "R6", "irq at end", irq, 1);
        peek(2'd2, v); chk(v == 8'h5A, "R5", "rx byte D=8", v, 8'h5A);

        // R9: write-zero keeps, write-one clears
        wr(2'd1, 8'h00);
        peek(2'd1, v); chk(v == 8'h01, "R9", "write 0 no effect", v, 1);
        wr(2'd1, 8'h01);
        peek(2'd1, v); chk(v == 8'h00 && !irq, "R9", "write 1 clears", v, 0);

        // R7: collision during a transfer
        slave = 8'h0F;
        wr(2'd2, 8'h81);
        repeat (5) @(negedge clk);
        wr(2'd2, 8'hEE);
        peek(2'd1, v); chk(v == 8'h02, "R7", "collision flag", v, 2);
        peek(2'd2, v); chk(v == 8'h81, "R7", "data kept", v, 8'h81);
        wait_idle();
        chk(last_run == 64, "R7", "no restart", last_run, 64);
        peek(2'd2, v); chk(v == 8'h0F, "R7", "rx after collision", v, 8'h0F);
        wr(2'd1, 8'h03);
        peek(2'd1, v); chk(v == 8'h02, "R9", "collision survives status write", v, 2);
        wr(2'd2, 8'h44);
        peek(2'd1, v); chk(v == 8'h00, "R8", "start clears collision", v, 0);
        wait_idle();

        // R11: divider change mid-transfer, divider 4
        wr(2'd0, 8'h0B);
        slave = 8'h96;
        wr(2'd2, 8'h69);
        repeat (3) @(negedge clk);
        wr(2'd0, 8'h1B);
        wait_idle();
        chk(last_run == 32, "R11", "latched divider", last_run, 32);
        peek(2'd2, v); chk(v == 8'h96, "R11", "rx byte", v, 8'h96);

        // R9: clear in the final cycle loses to completion
        wr(2'd0, 8'h03);
        wr(2'd2, 8'h11);
        wait_final();
        reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 8'h01;
        @(negedge clk); reg_wr = 1'b0;
        peek(2'd1, v); chk(v == 8'h01, "R9", "completion wins", v, 1);

        // R7: data write in the final cycle
        wr(2'd2, 8'h22);
        wait_final();
        reg_wr = 1'b1; reg_addr = 2'd2; reg_wdata = 8'hF0;
        @(negedge clk); reg_wr = 1'b0;
        peek(2'd1, v); chk(v == 8'h03, "R7", "final-cycle collision", v, 3);
        chk(!busy, "R7", "no restart at end", busy, 0);

        // R3: largest divider via select 7
        wr(2'd0, 8'h3B);
        slave = 8'hC6;
        wr(2'd2, 8'h5F);
        wait_idle();
        chk(last_run == 1024, "R3", "busy length D=128", last_run, 1024);
        peek(2'd2, v); chk(v == 8'hC6, "R5", "rx byte D=128", v, 8'hC6);

        repeat (4) @(negedge clk);
        summary();
    end

endmodule